// File: doc/BRIEF.md
# UART Multiprocessor Address Filter

This block sits behind a UART receiver that runs in nine-bit multiprocessor mode. Each received frame is a byte plus a ninth bit. A ninth bit of 1 marks an address frame, and a ninth bit of 0 marks a data frame. The block keeps two local registers: a node address and a per-bit enable mask. On every address frame it checks the byte against two patterns.

- **Node pattern.** Only the bits the mask enables must equal the node address.
- **Group (broadcast) pattern.** This is the OR of address and mask. Every bit that is 1 in it must also be 1 in the received byte.

A hit on either pattern opens the node for the data frames that follow. A miss closes it.

Software picks which address bits a node cares about, so a single address byte can reach one node, a chosen subset of nodes, or all of them. After reset both registers are zero. In that state every address hits both patterns and the filter does nothing. Bit timing and serial shifting are done upstream; this block sees only the byte-valid strobe.

Top module: `mp_addr_filter`

## Requirements
- R1: On an address frame, `match_kind[0]` is set when, for every bit where the mask register is 1, the received bit equals the address register bit. Bits where the mask is 0 are ignored.
- R2: On an address frame, `match_kind[1]` is set when every bit that is 1 in (address OR mask) is also 1 in the received byte. Bits that are 0 in that OR are ignored. Example: with address 0xC0 and mask 0xF9, byte 0xFF sets bit 1.
- R3: Reset clears both registers, `accept`, `match_kind` and `frame_take` to 0. With both registers at zero, any address frame gives `match_kind` = 2'b11.
- R4: An address frame that hits either pattern sets `accept` and pulses `frame_take` for one cycle. Both updates appear at the clock edge that samples the strobe.
- R5: An address frame that hits neither pattern clears `accept`, leaves `frame_take` at 0 and gives `match_kind` = 2'b00.
- R6: A data frame (ninth bit 0) pulses `frame_take` only if `accept` was 1 when the strobe was sampled. It leaves `accept` and `match_kind` unchanged.
- R7: A register write in the same cycle as an address strobe does not affect that comparison; the new value applies from the next frame.
- R8: Without a strobe, `accept` and `match_kind` hold and `frame_take` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_we | input | 1 | Write enable for the node address register |
| addr_wdata | input | DATA_W | New node address |
| mask_we | input | 1 | Write enable for the enable-mask register |
| mask_wdata | input | DATA_W | New enable mask |
| rx_valid | input | 1 | One-cycle strobe: a received frame is present |
| rx_byte | input | DATA_W | Received byte |
| rx_bit9 | input | 1 | Ninth bit: 1 for an address frame, 0 for a data frame |
| accept | output | 1 | Node is currently selected for data frames |
| match_kind | output | 2 | Result of the last address frame: bit 0 is the node pattern, bit 1 is the group pattern |
| frame_take | output | 1 | One-cycle pulse: the frame just sampled is taken |

## Verification
The assertions check these rules on every cycle:
- a data frame never moves `accept`;
- `frame_take` on a data frame copies the earlier `accept`;
- `accept` after an address frame agrees with `match_kind`;
- the outputs stay quiet when no strobe arrives;
- zeroed registers always give a double hit.

The exact per-bit decisions for chosen address and mask pairs, the choice of old register values on a write that collides with a strobe, and the cleared state after reset can be shown only by the bench's scenarios.

// File: rtl/mp_filter_pkg.sv
package mp_filter_pkg;
   typedef struct packed {
      logic grp;   // group (broadcast) pattern hit
      logic node;  // node pattern hit
   } match_t;

   localparam match_t MATCH_NONE = '{grp: 1'b0, node: 1'b0};
endpackage

// File: rtl/mp_addr_regs.sv
module mp_addr_regs #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_we,
   input  logic [DATA_W-1:0] addr_wdata,
   input  logic              mask_we,
   input  logic [DATA_W-1:0] mask_wdata,
   output logic [DATA_W-1:0] addr_q,
   output logic [DATA_W-1:0] mask_q
);
   // Written values are visible only after the edge, so a comparison
   // in the same cycle still sees the old contents.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         mask_q <= '0;
      end else begin
         if (addr_we) addr_q <= addr_wdata;
         if (mask_we) mask_q <= mask_wdata;
      end
   end
endmodule

// File: rtl/mp_addr_cmp.sv
module mp_addr_cmp
   import mp_filter_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] addr_q,
   input  logic [DATA_W-1:0] mask_q,
   input  logic [DATA_W-1:0] rx_byte,
   output match_t            hit
);
   logic [DATA_W-1:0] node_ok;
   logic [DATA_W-1:0] grp_ok;
   logic [DATA_W-1:0] grp_pat;

   assign grp_pat = addr_q | mask_q;

   // One slice per bit; both patterns reduce in parallel.
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign node_ok[b] = !mask_q[b] || (rx_byte[b] == addr_q[b]);
      assign grp_ok[b]  = !grp_pat[b] || rx_byte[b];
   end

   assign hit.node = &node_ok;
   assign hit.grp  = &grp_ok;
endmodule

// File: rtl/mp_accept_ctl.sv
module mp_accept_ctl
   import mp_filter_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_valid,
   input  logic       rx_bit9,
   input  match_t     hit,
   output logic       accept,
   output match_t     kind,
   output logic       take
);
   logic any_hit;
   assign any_hit = hit.node | hit.grp;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         accept <= 1'b0;
         kind   <= MATCH_NONE;
         take   <= 1'b0;
      end else begin
         take <= 1'b0;
         if (rx_valid) begin
            if (rx_bit9) begin
               accept <= any_hit;
               kind   <= hit;
               take   <= any_hit;
            end else begin
               take   <= accept;
            end
         end
      end
   end
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter
   import mp_filter_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_we,
   input  logic [DATA_W-1:0] addr_wdata,
   input  logic              mask_we,
   input  logic [DATA_W-1:0] mask_wdata,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              rx_bit9,
   output logic              accept,
   output logic [1:0]        match_kind,
   output logic              frame_take
);
   if (DATA_W < 2 || DATA_W > 16) begin : g_bad_width
      $error("mp_addr_filter: DATA_W must be within 2..16");
   end

   logic [DATA_W-1:0] addr_q;
   logic [DATA_W-1:0] mask_q;
   match_t            hit;
   match_t            kind;

   mp_addr_regs #(.DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_we    (addr_we),
      .addr_wdata (addr_wdata),
      .mask_we    (mask_we),
      .mask_wdata (mask_wdata),
      .addr_q     (addr_q),
      .mask_q     (mask_q)
   );

   mp_addr_cmp #(.DATA_W(DATA_W)) u_cmp (
      .addr_q  (addr_q),
      .mask_q  (mask_q),
      .rx_byte (rx_byte),
      .hit     (hit)
   );

   mp_accept_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_valid (rx_valid),
      .rx_bit9  (rx_bit9),
      .hit      (hit),
      .accept   (accept),
      .kind     (kind),
      .take     (frame_take)
   );

   assign match_kind = kind;
endmodule

// File: rtl/mp_addr_filter_chk.sv
module mp_addr_filter_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic              rx_bit9,
   input logic [DATA_W-1:0] addr_q,
   input logic [DATA_W-1:0] mask_q,
   input logic              accept,
   input logic [1:0]        match_kind,
   input logic              frame_take
);
   // R6: data frames never move the selection or the last result
   p_data_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_bit9 |=> $stable(accept) && $stable(match_kind));

   // R6: a data frame is taken exactly when the node was selected
   p_data_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_bit9 |=> frame_take == $past(accept));

   // R4 / R5: selection after an address frame agrees with its result
   p_addr_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_bit9 |=> (accept == (match_kind != 2'b00)) && (frame_take == accept));

   // R8: no strobe means no change and no pulse
   p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> $stable(accept) && $stable(match_kind) && !frame_take);

   // R3: zeroed registers let every address hit both patterns
   p_open_filter_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_bit9 && addr_q == '0 && mask_q == '0 |=> match_kind == 2'b11);
endmodule

bind mp_addr_filter mp_addr_filter_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid   (rx_valid),
   .rx_bit9    (rx_bit9),
   .addr_q     (addr_q),
   .mask_q     (mask_q),
   .accept     (accept),
   .match_kind (match_kind),
   .frame_take (frame_take)
);

// File: tb/tb_mp_addr_filter.sv
`timescale 1ns/1ps
module tb_mp_addr_filter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       addr_we = 1'b0, mask_we = 1'b0;
   logic [7:0] addr_wdata = '0, mask_wdata = '0;
   logic       rx_valid = 1'b0, rx_bit9 = 1'b0;
   logic [7:0] rx_byte = '0;
   logic       accept, frame_take;
   logic [1:0] match_kind;

   int errors = 0, checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mp_addr_filter #(.DATA_W(8)) dut (
      .clk(clk), .rst_n(rst_n),
      .addr_we(addr_we), .addr_wdata(addr_wdata),
      .mask_we(mask_we), .mask_wdata(mask_wdata),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_bit9(rx_bit9),
      .accept(accept), .match_kind(match_kind), .frame_take(frame_take)
   );

   // {address, mask, received byte, expected {group,node}}
   localparam int NV = 10;
   localparam logic [25:0] VEC [NV] = '{
      {8'hC0, 8'hF9, 8'hC6, 2'b01},
      {8'hC0, 8'hF9, 8'hFF, 2'b10},
      {8'hE0, 8'hFA, 8'hE4, 2'b01},
      {8'hE0, 8'hFC, 8'hE4, 2'b00},
      {8'hE0, 8'hFC, 8'hE3, 2'b01},
      {8'h00, 8'h00, 8'h5A, 2'b11},
      {8'h12, 8'hFF, 8'h12, 2'b01},
      {8'h00, 8'hFF, 8'hFF, 2'b10},
      {8'hE0, 8'hFA, 8'hE1, 2'b01},
      {8'hC0, 8'hF9, 8'hC8, 2'b00}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_regs(input logic [7:0] a, input logic [7:0] m);
      @(negedge clk);
      addr_we = 1'b1; addr_wdata = a; mask_we = 1'b1; mask_wdata = m;
      @(negedge clk);
      addr_we = 1'b0; mask_we = 1'b0;
   endtask

   // Drives one frame; returns at the following negedge, after the sampling edge.
   task automatic send(input logic bit9, input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_bit9 = bit9; rx_byte = b;
      @(negedge clk);
      rx_valid = 1'b0; rx_bit9 = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R3: cleared state
      chk("R3 accept", {7'd0, accept}, 8'd0);
      chk("R3 match_kind", {6'd0, match_kind}, 8'd0);
      chk("R3 frame_take", {7'd0, frame_take}, 8'd0);
      rst_n = 1'b1;
      send(1'b1, 8'h37);
      chk("R3 open filter kind", {6'd0, match_kind}, 8'd3);
      chk("R4 accept after hit", {7'd0, accept}, 8'd1);
      chk("R4 take pulse", {7'd0, frame_take}, 8'd1);

      // R1 / R2 table
      for (int i = 0; i < NV; i++) begin
         wr_regs(VEC[i][25:18], VEC[i][17:10]);
         send(1'b1, VEC[i][9:2]);
         chk("R1 node bit", {7'd0, match_kind[0]}, {7'd0, VEC[i][0]});
         chk("R2 group bit", {7'd0, match_kind[1]}, {7'd0, VEC[i][1]});
         chk("R4/R5 accept", {7'd0, accept}, {7'd0, |VEC[i][1:0]});
         chk("R4/R5 take", {7'd0, frame_take}, {7'd0, |VEC[i][1:0]});
      end

      // R6 data taken while selected, R8 idle
      wr_regs(8'hE0, 8'hFC);
      send(1'b1, 8'hE3);
      send(1'b0, 8'h55);
      chk("R6 data take", {7'd0, frame_take}, 8'd1);
      chk("R6 accept held", {7'd0, accept}, 8'd1);
      chk("R6 kind held", {6'd0, match_kind}, 8'd1);
      @(negedge clk);
      chk("R8 idle take", {7'd0, frame_take}, 8'd0);
      chk("R8 idle accept", {7'd0, accept}, 8'd1);

      // R5 miss closes, then data ignored
      send(1'b1, 8'hC8);
      chk("R5 accept cleared", {7'd0, accept}, 8'd0);
      chk("R5 no take", {7'd0, frame_take}, 8'd0);
      send(1'b0, 8'hE3);
      chk("R6 data dropped", {7'd0, frame_take}, 8'd0);
      chk("R6 kind unchanged", {6'd0, match_kind}, 8'd0);

      // R7 write colliding with strobe uses old mask 0xFC
      @(negedge clk);
      mask_we = 1'b1; mask_wdata = 8'hFA;
      rx_valid = 1'b1; rx_bit9 = 1'b1; rx_byte = 8'hE4;
      @(negedge clk);
      mask_we = 1'b0; rx_valid = 1'b0; rx_bit9 = 1'b0;
      chk("R7 old value used", {6'd0, match_kind}, 8'd0);
      send(1'b1, 8'hE4);
      chk("R7 new value next frame", {6'd0, match_kind}, 8'd1);

      // R3 reset mid-run clears registers
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk("R3 reset accept", {7'd0, accept}, 8'd0);
      chk("R3 reset kind", {6'd0, match_kind}, 8'd0);
      rst_n = 1'b1;
      send(1'b1, 8'h00);
      chk("R3 registers cleared", {6'd0, match_kind}, 8'd3);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule